// File: doc/BRIEF.md
# Escalating Three-Stage Watchdog Timer

This block guards one processor core. Software arms it with a single configuration write carrying a 16-bit length and a 2-bit escalation mode. Once armed, a power-of-two prescaler divides the clock and drives a decrementer. The length sets the top bits of the decrementer and the low bits reload to all ones.

Every time the decrementer runs out without a poke, the watchdog climbs one stage. The first expiry raises an interrupt. The second raises a non-maskable interrupt. The third issues a one-cycle chip soft-reset request. The mode limits how far this climb may go. A poke at any time restarts the period and drops back to the first stage. The live count and the current stage are visible on output ports, so a status register can show them.

Top module: `esc_wdog`

## Requirements
- R1: After a synchronous reset, the block is disabled. `irq_o`, `nmi_o` and `rst_req_o` are low, `stage_o` is 0 and `cnt_o` is 0. It stays that way until a configuration write with a nonzero mode arrives.
- R2: A configuration write with a nonzero mode arms the watchdog. From the next cycle, `cnt_o` equals the length in its upper LEN_W bits with all FRAC_W low bits set to one, and `stage_o` is 0.
- R3: While armed, `cnt_o` decreases by one every 2^PRE_LOG2 clock cycles. When it is at 0 and takes another step, it reloads instead, so one period is (length+1) * 2^FRAC_W prescaled ticks.
- R4: In mode 3, `stage_o` reads 1 with `irq_o` high after the first unpoked period. It reads 2 with `nmi_o` high after the second period. It reads 3 after the third period, with `rst_req_o` high for exactly one cycle. Further expiries leave stage 3 and give no further pulse.
- R5: `irq_o` and `nmi_o` are levels. Once raised, they stay high until a poke, a new configuration or a reset.
- R6: In mode 1, only the interrupt stage is reached. `stage_o` stays at 1 and `nmi_o` stays low.
- R7: In mode 2, the interrupt and then the non-maskable interrupt are reached. `stage_o` stays at 2, `nmi_o` is only ever high together with `irq_o`, and `rst_req_o` never rises.
- R8: A configuration write with mode 0 disables the block at once. The outputs drop, `cnt_o` is held at 0 and `stage_o` at 0, and pokes have no effect while the block is disabled.
- R9: A poke while armed reloads `cnt_o` from the stored length, sets `stage_o` to 0 and clears `irq_o` and `nmi_o` on the next cycle.
- R10: A configuration write while armed takes the new length and mode, reloads the counter and restarts from stage 0.
- R11: A length of 0 with a nonzero mode gives a period of 2^FRAC_W prescaled ticks. The first expiry comes no sooner than that.
- R12: A poke in the same cycle as an expiry wins. The stage stays 0 and a fresh full period begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_len | input | LEN_W | Period length, upper bits of the decrementer |
| cfg_mode | input | 2 | 0 off, 1 interrupt only, 2 up to NMI, 3 up to soft reset |
| poke | input | 1 | Restart strobe |
| irq_o | output | 1 | Interrupt level (stage 1 and above) |
| nmi_o | output | 1 | Non-maskable interrupt level (stage 2 and above) |
| rst_req_o | output | 1 | One-cycle soft-reset request on entry to stage 3 |
| cnt_o | output | LEN_W+FRAC_W | Live decrementer value |
| stage_o | output | 2 | Current stage, 0 to 3 |

## Verification
The decrementer is visible on `cnt_o` every cycle. A wrong reload pattern appears one cycle after an arming write or a poke. A wrong prescale ratio appears within one divisor interval. A stage register that advances wrongly, or that ignores the mode limit, appears on `irq_o`, `nmi_o` or `rst_req_o` at the very next expiry edge. For that reason the bench samples just before and just after each expected expiry. A lost poke priority only shows at the exact edge where the poke and the expiry coincide, so that edge is hit on purpose.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    STG_WAIT = 2'd0,
    STG_IRQ  = 2'd1,
    STG_NMI  = 2'd2,
    STG_RST  = 2'd3
  } stage_e;

  localparam logic [1:0] MODE_OFF  = 2'd0;
  localparam logic [1:0] MODE_IRQ  = 2'd1;
  localparam logic [1:0] MODE_NMI  = 2'd2;
  localparam logic [1:0] MODE_FULL = 2'd3;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PRE_LOG2 = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam logic [PRE_LOG2-1:0] PRE_LAST = {PRE_LOG2{1'b1}};

  logic [PRE_LOG2-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || clear || !run) pre_q <= '0;
    else                      pre_q <= pre_q + 1'b1;
  end

  assign tick = run && (pre_q == PRE_LAST);

  // R3: ticks are never back to back when the divisor is at least 2
  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/wdog_decrementer.sv
module wdog_decrementer #(
  parameter int LEN_W  = 16,
  parameter int FRAC_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    load,
  input  logic [LEN_W-1:0]        load_len,
  input  logic [LEN_W-1:0]        reload_len,
  input  logic                    tick,
  output logic [LEN_W+FRAC_W-1:0] cnt,
  output logic                    expire
);
  localparam int CNT_W = LEN_W + FRAC_W;
  localparam logic [FRAC_W-1:0] FRAC_ONES = {FRAC_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)   cnt_q <= '0;
    else if (load)    cnt_q <= {load_len, FRAC_ONES};
    else if (tick) begin
      if (cnt_q == '0) cnt_q <= {reload_len, FRAC_ONES};
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt    = cnt_q;
  assign expire = tick && (cnt_q == '0) && !load && !clr;

  // R11: a fresh load never leaves the counter at zero
  p_load_nonzero_r11: assert property (@(posedge clk) disable iff (rst)
    (load && !clr) |=> (cnt_q != '0));
endmodule

// File: rtl/wdog_stage_fsm.sv
module wdog_stage_fsm
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       off,
  input  logic       restart,
  input  logic       expire,
  input  logic [1:0] mode,
  output stage_e     stage,
  output logic       irq,
  output logic       nmi,
  output logic       rst_req
);
  stage_e stage_q;
  logic   irq_q, nmi_q, req_q;

  always_ff @(posedge clk) begin
    if (rst || off || restart) begin
      stage_q <= STG_WAIT;
      irq_q   <= 1'b0;
      nmi_q   <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (expire) begin
        unique case (stage_q)
          STG_WAIT: begin
            stage_q <= STG_IRQ;
            irq_q   <= 1'b1;
          end
          STG_IRQ: if (mode == MODE_NMI || mode == MODE_FULL) begin
            stage_q <= STG_NMI;
            nmi_q   <= 1'b1;
          end
          STG_NMI: if (mode == MODE_FULL) begin
            stage_q <= STG_RST;
            req_q   <= 1'b1;
          end
          STG_RST: ;
          default: ;
        endcase
      end
    end
  end

  assign stage   = stage_q;
  assign irq     = irq_q;
  assign nmi     = nmi_q;
  assign rst_req = req_q;

  // R4: the reset request lasts one cycle only
  p_req_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);
  // R7: NMI is never raised without the interrupt
  p_nmi_with_irq_r7: assert property (@(posedge clk) disable iff (rst)
    nmi |-> irq);
  // R6: interrupt-only mode never reaches NMI
  p_mode1_no_nmi_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_IRQ) |-> !nmi);
  // R9: a restart returns to the first stage with levels cleared
  p_restart_clears_r9: assert property (@(posedge clk) disable iff (rst)
    restart |=> (stage == STG_WAIT && !irq && !nmi));
endmodule

// File: rtl/esc_wdog.sv
module esc_wdog
  import wdog_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int FRAC_W   = 8,
  parameter int PRE_LOG2 = 8,
  localparam int CNT_W   = LEN_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [1:0]       cfg_mode,
  input  logic             poke,
  output logic             irq_o,
  output logic             nmi_o,
  output logic             rst_req_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [1:0]       stage_o
);
  logic [LEN_W-1:0] len_q;
  logic [1:0]       mode_q;
  logic             en_q;

  logic   cfg_off, cfg_arm, poke_live, restart, tick, expire;
  stage_e stage;

  assign cfg_off   = cfg_we && (cfg_mode == MODE_OFF);
  assign cfg_arm   = cfg_we && (cfg_mode != MODE_OFF);
  assign poke_live = poke && en_q && !cfg_we;
  assign restart   = cfg_arm || poke_live;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q  <= '0;
      mode_q <= MODE_OFF;
      en_q   <= 1'b0;
    end else if (cfg_we) begin
      len_q  <= cfg_len;
      mode_q <= cfg_mode;
      en_q   <= (cfg_mode != MODE_OFF);
    end
  end

  wdog_prescaler #(.PRE_LOG2(PRE_LOG2)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .clear (restart || cfg_off),
    .run   (en_q),
    .tick  (tick)
  );

  wdog_decrementer #(.LEN_W(LEN_W), .FRAC_W(FRAC_W)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .clr        (cfg_off),
    .load       (restart),
    .load_len   (cfg_we ? cfg_len : len_q),
    .reload_len (len_q),
    .tick       (tick),
    .cnt        (cnt_o),
    .expire     (expire)
  );

  wdog_stage_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .off     (cfg_off),
    .restart (restart),
    .expire  (expire),
    .mode    (mode_q),
    .stage   (stage),
    .irq     (irq_o),
    .nmi     (nmi_o),
    .rst_req (rst_req_o)
  );

  assign stage_o = stage;

  // R8: while disabled everything is quiet and the counter holds zero
  p_off_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> (stage_o == 2'd0 && !irq_o && !nmi_o && cnt_o == '0));
  // R4: the soft-reset request appears only in full-escalation mode
  p_req_mode3_r4: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> (mode_q == MODE_FULL));
endmodule

// File: tb/esc_wdog_tb.sv
module esc_wdog_tb;
  localparam int LEN_W    = 16;
  localparam int FRAC_W   = 2;
  localparam int PRE_LOG2 = 2;
  localparam int CNT_W    = LEN_W + FRAC_W;
  localparam int DIV      = 1 << PRE_LOG2;

  typedef struct packed {
    logic [1:0]  mode;
    logic [15:0] len;
    logic [15:0] ofs;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{2'd3, 16'd1, 16'd3},   '{2'd3, 16'd1, 16'd4},
    '{2'd3, 16'd1, 16'd31},  '{2'd3, 16'd1, 16'd32},
    '{2'd3, 16'd1, 16'd63},  '{2'd3, 16'd1, 16'd64},
    '{2'd3, 16'd1, 16'd96},  '{2'd3, 16'd1, 16'd130},
    '{2'd1, 16'd1, 16'd32},  '{2'd1, 16'd1, 16'd100},
    '{2'd2, 16'd1, 16'd64},  '{2'd2, 16'd1, 16'd120},
    '{2'd3, 16'd0, 16'd15},  '{2'd3, 16'd0, 16'd16},
    '{2'd3, 16'd0, 16'd1},   '{2'd3, 16'd2, 16'd47},
    '{2'd3, 16'd2, 16'd48},  '{2'd2, 16'd2, 16'd150}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_we = 1'b0;
  logic [LEN_W-1:0] cfg_len = '0;
  logic [1:0]       cfg_mode = 2'd0;
  logic             poke = 1'b0;
  logic             irq_o, nmi_o, rst_req_o;
  logic [CNT_W-1:0] cnt_o;
  logic [1:0]       stage_o;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #5 clk = ~clk;

  esc_wdog #(.LEN_W(LEN_W), .FRAC_W(FRAC_W), .PRE_LOG2(PRE_LOG2)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_len(cfg_len),
    .cfg_mode(cfg_mode), .poke(poke), .irq_o(irq_o), .nmi_o(nmi_o),
    .rst_req_o(rst_req_o), .cnt_o(cnt_o), .stage_o(stage_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    if (n > 0) begin
      repeat (n) @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_cfg(input logic [1:0] m, input logic [LEN_W-1:0] l);
    cfg_mode = m; cfg_len = l; cfg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_poke();
    poke = 1'b1;
    @(posedge clk); @(negedge clk);
    poke = 1'b0;
  endtask

  function automatic int period_of(input int len);
    return (len + 1) * (1 << FRAC_W) * DIV;
  endfunction

  function automatic int exp_cnt(input int len, input int k);
    int c;
    c = (len << FRAC_W) | ((1 << FRAC_W) - 1);
    return c - (k % period_of(len)) / DIV;
  endfunction

  function automatic int exp_stage(input int mode, input int len, input int k);
    int s;
    s = k / period_of(len);
    return (s > mode) ? mode : s;
  endfunction

  function automatic string tag_of(input int mode, input int len, input int k);
    if (k < period_of(len)) return (len == 0) ? "R11" : "R3";
    if (mode == 1) return "R6";
    if (mode == 2) return "R7";
    return "R4";
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 irq", irq_o, 0);
    chk("R1 nmi", nmi_o, 0);
    chk("R1 stage", stage_o, 0);
    chk("R1 cnt", cnt_o, 0);
    edges(40);
    chk("R1 idle cnt", cnt_o, 0);

    // R2: arming loads length with low ones
    do_cfg(2'd3, 16'd5);
    chk("R2 cnt", cnt_o, (5 << FRAC_W) | 3);
    chk("R2 stage", stage_o, 0);

    // Table walk: R3 R4 R6 R7 R11
    for (int i = 0; i < NV; i++) begin
      int m, l, k, s;
      string t;
      m = VECS[i].mode; l = VECS[i].len; k = VECS[i].ofs;
      do_cfg(2'd0, 16'd0);
      do_cfg(VECS[i].mode, VECS[i].len);
      edges(k);
      s = exp_stage(m, l, k);
      t = tag_of(m, l, k);
      chk({t, " stage"}, stage_o, s);
      chk({t, " irq"}, irq_o, (s >= 1) ? 1 : 0);
      chk({t, " nmi"}, nmi_o, (s >= 2) ? 1 : 0);
      chk({t, " cnt"}, cnt_o, exp_cnt(l, k));
    end

    // R4: reset request pulse width and no repeat
    do_cfg(2'd0, 16'd0);
    do_cfg(2'd3, 16'd0);
    edges(47);
    chk("R4 req before", rst_req_o, 0);
    edges(1);
    chk("R4 req pulse", rst_req_o, 1);
    chk("R4 stage3", stage_o, 3);
    edges(1);
    chk("R4 req drop", rst_req_o, 0);
    edges(15);
    chk("R4 no repeat", rst_req_o, 0);
    chk("R4 hold stage3", stage_o, 3);
    chk("R5 irq held", irq_o, 1);

    // R9: poke clears escalation
    do_cfg(2'd0, 16'd0);
    do_cfg(2'd3, 16'd0);
    edges(40);
    chk("R9 pre nmi", nmi_o, 1);
    do_poke();
    chk("R9 stage", stage_o, 0);
    chk("R9 irq", irq_o, 0);
    chk("R9 nmi", nmi_o, 0);
    chk("R9 cnt", cnt_o, 3);
    edges(15);
    chk("R9 no early irq", irq_o, 0);
    edges(1);
    chk("R9 irq again", irq_o, 1);

    // R12: poke on the expiry edge wins
    do_cfg(2'd0, 16'd0);
    do_cfg(2'd3, 16'd0);
    edges(15);
    chk("R12 cnt zero", cnt_o, 0);
    do_poke();
    chk("R12 stage", stage_o, 0);
    chk("R12 irq", irq_o, 0);
    chk("R12 cnt", cnt_o, 3);
    edges(15);
    chk("R12 still wait", stage_o, 0);
    edges(1);
    chk("R12 later irq", stage_o, 1);

    // R10: reconfigure while running
    do_cfg(2'd0, 16'd0);
    do_cfg(2'd3, 16'd0);
    edges(20);
    chk("R10 running irq", irq_o, 1);
    do_cfg(2'd2, 16'd1);
    chk("R10 stage", stage_o, 0);
    chk("R10 irq", irq_o, 0);
    chk("R10 cnt", cnt_o, 7);
    edges(31);
    chk("R10 wait", stage_o, 0);
    edges(1);
    chk("R10 new period", stage_o, 1);

    // R8: disable and ignored pokes
    do_cfg(2'd3, 16'd0);
    edges(20);
    chk("R8 armed irq", irq_o, 1);
    do_cfg(2'd0, 16'd7);
    chk("R8 irq", irq_o, 0);
    chk("R8 stage", stage_o, 0);
    chk("R8 cnt", cnt_o, 0);
    edges(100);
    chk("R8 idle irq", irq_o, 0);
    do_poke();
    chk("R8 poke cnt", cnt_o, 0);
    chk("R8 poke stage", stage_o, 0);
    edges(50);
    chk("R8 still idle", irq_o, 0);

    // R1: reset in the middle of a run
    do_cfg(2'd3, 16'd0);
    edges(36);
    chk("R1 pre nmi", nmi_o, 1);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    chk("R1 mid irq", irq_o, 0);
    chk("R1 mid nmi", nmi_o, 0);
    chk("R1 mid cnt", cnt_o, 0);
    edges(80);
    chk("R1 stays off", irq_o, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog R1-run actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule